// File: doc/BRIEF.md
# Transmit Burst Transaction Sequencer

This block cuts one outgoing packet into a series of 32-bit write transactions for a bus master engine. Software-visible settings choose the bus command code, the number of beats per burst, a half-width lane mode and a fixed-address mode. A packet is started with a base address and a byte length. The sequencer then issues one request at a time. Each request carries the command, the current address, a beat count and a byte-enable mask. After each request the sequencer waits for the bus engine to report how many beats it accepted.

Before it requests a full burst, the sequencer waits until the transmit FIFO holds enough bytes for that burst. Once the tail of the packet is shorter than one full burst, it sends single-beat transactions. When a transaction is disconnected early, the bytes that were not accepted are requested again from the advanced address. A one-cycle pulse marks the end of each packet.

Top module: `tx_burst_seq`

## Requirements
- R1: After reset the command setting is 4'b0111, the burst setting and both mode flags are 0, and req_valid, busy and pkt_done are low.
- R2: Every request presents on req_cmd the command setting held when the request was formed.
- R3: A full burst has as many beats as the 3-bit burst setting, and a setting of 0 means 8 beats. Each beat is 4 bytes.
- R4: A request is raised only if, in the cycle it was formed, fifo_level was at least 4 × req_beats.
- R5: When the bytes left in the packet are fewer than one full burst, each request has req_beats = 1.
- R6: req_be is 4'b0011 when the word-only setting is 1 and 4'b1111 when it is 0. Bit i enables byte lane i.
- R7: With the address-hold setting at 0, the address advances by 4 × accepted beats after each response. With it at 1, every request of the packet carries the start address.
- R8: req_valid stays high until req_accept is seen, and req_addr, req_beats and req_be are stable while it is high.
- R9: A response with fewer beats than requested reduces the remaining bytes by the accepted amount only. The next request is then formed again from the remaining bytes.
- R10: pkt_done is high for exactly the cycle after the response that finishes the packet. A zero-length packet raises pkt_done in the cycle after pkt_start and makes no request.
- R11: busy is high from the cycle after an accepted pkt_start until the packet ends. pkt_start has no effect while busy.
- R12: A settings write during a packet takes effect from the next request formed, and never alters a request that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the four settings below |
| cfg_cmd | input | 4 | Bus command code |
| cfg_burst | input | 3 | Beats per burst, 0 means 8 |
| cfg_word_only | input | 1 | Enable only the two low byte lanes |
| cfg_addr_hold | input | 1 | Keep the address fixed |
| pkt_start | input | 1 | Start a packet (idle only) |
| pkt_addr | input | ADDR_W | Packet start address |
| pkt_len | input | LEN_W | Packet length in bytes, a multiple of 4 |
| fifo_level | input | LVL_W | Bytes held in the transmit FIFO |
| req_valid | output | 1 | Transaction request pending |
| req_cmd | output | 4 | Command for the address phase |
| req_addr | output | ADDR_W | Transaction address |
| req_beats | output | 4 | Beats requested, 1 to 8 |
| req_be | output | 4 | Byte enables |
| req_accept | input | 1 | Request taken by the bus engine |
| resp_valid | input | 1 | Transaction finished or disconnected |
| resp_beats | input | 4 | Beats accepted by the bus |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| busy | output | 1 | Packet in progress |

## Verification
The checks assume that the bus engine raises req_accept only while req_valid is high. They also assume resp_valid arrives only after an accept, at most once per request, with resp_beats never above the beats requested, and that pkt_len is a multiple of 4. The bench responder accepts only pending requests and returns either the full beat count or a random smaller one, zero included. Every packet length it drives is a multiple of 4. The FIFO level is either held high or redrawn at random each cycle, so the burst gate is tried on both sides of its threshold.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
  localparam logic [3:0] BE_ALL_LANES  = 4'b1111;
  localparam logic [3:0] BE_LOW_LANES  = 4'b0011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_REQ,
    ST_RESP
  } seq_state_t;

  typedef struct packed {
    logic [3:0] cmd;
    logic [2:0] burst;
    logic       word_only;
    logic       addr_hold;
  } seq_cfg_t;

  // Beats in a full burst; the zero code selects the largest burst.
  function automatic logic [3:0] burst_beats(input logic [2:0] field);
    return (field == 3'd0) ? 4'd8 : {1'b0, field};
  endfunction

  // Bytes moved by a number of 4-byte beats.
  function automatic logic [5:0] beats_to_bytes(input logic [3:0] beats);
    return {beats, 2'b00};
  endfunction

  function automatic logic [3:0] lane_mask(input logic word_only);
    return word_only ? BE_LOW_LANES : BE_ALL_LANES;
  endfunction

endpackage

// File: rtl/tbs_cfg_reg.sv
module tbs_cfg_reg
  import tbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_cmd,
  input  logic [2:0] cfg_burst,
  input  logic       cfg_word_only,
  input  logic       cfg_addr_hold,
  output seq_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.cmd       <= CMD_MEM_WRITE;
      cfg.burst     <= 3'd0;
      cfg.word_only <= 1'b0;
      cfg.addr_hold <= 1'b0;
    end else if (cfg_we) begin
      cfg.cmd       <= cfg_cmd;
      cfg.burst     <= cfg_burst;
      cfg.word_only <= cfg_word_only;
      cfg.addr_hold <= cfg_addr_hold;
    end
  end

endmodule

// File: rtl/tbs_planner.sv
module tbs_planner
  import tbs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LVL_W = 10
) (
  input  logic [2:0]       burst_field,
  input  logic [LEN_W-1:0] rem_bytes,
  input  logic [LVL_W-1:0] fifo_level,
  output logic [3:0]       plan_beats,
  output logic             plan_ready
);

  logic [3:0] full_beats;
  logic [5:0] full_bytes;
  logic [5:0] need_bytes;
  logic       tail_short;

  always_comb begin
    full_beats = burst_beats(burst_field);
    full_bytes = beats_to_bytes(full_beats);
    tail_short = rem_bytes < LEN_W'(full_bytes);
    plan_beats = tail_short ? 4'd1 : full_beats;
    need_bytes = beats_to_bytes(plan_beats);
    plan_ready = fifo_level >= LVL_W'(need_bytes);
  end

endmodule

// File: rtl/tbs_tracker.sv
module tbs_tracker
  import tbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  input  logic [3:0]        step_beats,
  input  logic              hold,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  rem_bytes,
  output logic              rem_clears
);

  logic [LEN_W-1:0] step_len;

  assign step_len   = LEN_W'(beats_to_bytes(step_beats));
  assign rem_clears = (rem_bytes == step_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      rem_bytes <= '0;
    end else if (load) begin
      cur_addr  <= load_addr;
      rem_bytes <= load_len;
    end else if (step) begin
      rem_bytes <= rem_bytes - step_len;
      if (!hold) cur_addr <= cur_addr + ADDR_W'(beats_to_bytes(step_beats));
    end
  end

endmodule

// File: rtl/tx_burst_seq.sv
module tx_burst_seq
  import tbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LVL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_cmd,
  input  logic [2:0]        cfg_burst,
  input  logic              cfg_word_only,
  input  logic              cfg_addr_hold,
  input  logic              pkt_start,
  input  logic [ADDR_W-1:0] pkt_addr,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              req_valid,
  output logic [3:0]        req_cmd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [3:0]        req_beats,
  output logic [3:0]        req_be,
  input  logic              req_accept,
  input  logic              resp_valid,
  input  logic [3:0]        resp_beats,
  output logic              pkt_done,
  output logic              busy
);

  seq_cfg_t          cfg;
  seq_state_t        state, state_nx;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem_bytes;
  logic              rem_clears;
  logic [3:0]        plan_beats;
  logic              plan_ready;
  logic              req_hold_q;

  // Named internal events
  logic start_take, start_empty, start_load;
  logic issue_go, accept_take, resp_take, last_ack;

  tbs_cfg_reg u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_cmd       (cfg_cmd),
    .cfg_burst     (cfg_burst),
    .cfg_word_only (cfg_word_only),
    .cfg_addr_hold (cfg_addr_hold),
    .cfg           (cfg)
  );

  tbs_planner #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_plan (
    .burst_field (cfg.burst),
    .rem_bytes   (rem_bytes),
    .fifo_level  (fifo_level),
    .plan_beats  (plan_beats),
    .plan_ready  (plan_ready)
  );

  tbs_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_load),
    .load_addr  (pkt_addr),
    .load_len   (pkt_len),
    .step       (resp_take),
    .step_beats (resp_beats),
    .hold       (req_hold_q),
    .cur_addr   (cur_addr),
    .rem_bytes  (rem_bytes),
    .rem_clears (rem_clears)
  );

  assign start_take  = (state == ST_IDLE) && pkt_start;
  assign start_empty = (pkt_len == '0);
  assign start_load  = start_take && !start_empty;
  assign issue_go    = (state == ST_ISSUE) && plan_ready;
  assign accept_take = (state == ST_REQ) && req_accept;
  assign resp_take   = (state == ST_RESP) && resp_valid;
  assign last_ack    = resp_take && rem_clears;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_load)  state_nx = ST_ISSUE;
      ST_ISSUE: if (issue_go)    state_nx = ST_REQ;
      ST_REQ:   if (accept_take) state_nx = ST_RESP;
      ST_RESP:  if (resp_take)   state_nx = last_ack ? ST_IDLE : ST_ISSUE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pkt_done   <= 1'b0;
      req_cmd    <= '0;
      req_addr   <= '0;
      req_beats  <= '0;
      req_be     <= '0;
      req_hold_q <= 1'b0;
    end else begin
      state    <= state_nx;
      pkt_done <= (start_take && start_empty) || last_ack;
      if (issue_go) begin
        req_cmd    <= cfg.cmd;
        req_addr   <= cur_addr;
        req_beats  <= plan_beats;
        req_be     <= lane_mask(cfg.word_only);
        req_hold_q <= cfg.addr_hold;
      end
    end
  end

  assign req_valid = (state == ST_REQ);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/tbs_chk.sv
module tbs_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LVL_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_accept,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_beats,
  input logic [3:0]        req_be,
  input logic [LVL_W-1:0]  fifo_level,
  input logic [LEN_W-1:0]  rem_bytes,
  input logic              pkt_done,
  input logic              busy
);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_accept) |=> (req_valid && $stable(req_addr)
                                    && $stable(req_beats) && $stable(req_be)));

  // R4
  fifo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (int'($past(fifo_level)) >= int'(req_beats) * 4));

  // R6
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be == 4'b1111 || req_be == 4'b0011));

  // R5
  beats_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats >= 4'd1 && req_beats <= 4'd8
                   && int'(req_beats) * 4 <= int'(rem_bytes)));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (!req_valid && !busy));

endmodule

bind tx_burst_seq tbs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_accept (req_accept),
  .req_addr   (req_addr),
  .req_beats  (req_beats),
  .req_be     (req_be),
  .fifo_level (fifo_level),
  .rem_bytes  (rem_bytes),
  .pkt_done   (pkt_done),
  .busy       (busy)
);

// File: tb/tx_burst_seq_test.sv
module tx_burst_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_cmd = '0;
  logic [2:0]  cfg_burst = '0;
  logic        cfg_word_only = 1'b0;
  logic        cfg_addr_hold = 1'b0;
  logic        pkt_start = 1'b0;
  logic [31:0] pkt_addr = '0;
  logic [15:0] pkt_len = '0;
  logic [9:0]  fifo_level = 10'd64;
  logic        req_valid;
  logic [3:0]  req_cmd;
  logic [31:0] req_addr;
  logic [3:0]  req_beats;
  logic [3:0]  req_be;
  logic        req_accept = 1'b0;
  logic        resp_valid = 1'b0;
  logic [3:0]  resp_beats = '0;
  logic        pkt_done;
  logic        busy;

  always #10 clk = ~clk;

  tx_burst_seq uut (.*);

  int checks = 0, fails = 0, cycles = 0, done_seen = 0, pkts = 0;
  bit fifo_rand = 0, disc_en = 0, monitor_on = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference
  int m_st = 0, m_rem = 0, m_burst = 0, r_beats = 0, nb = 0;
  logic [31:0] m_addr = '0, r_addr = '0;
  logic [3:0]  m_cmd = 4'd7, r_cmd = '0, r_be = '0;
  bit m_wo = 0, m_hold = 0, r_hold = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_cmd = 4'd7; m_burst = 0; m_wo = 0; m_hold = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (pkt_start) begin
             m_addr = pkt_addr; m_rem = int'(pkt_len);
             if (m_rem == 0) m_done = 1; else m_st = 1;
           end
        1: begin
             nb = (m_burst == 0) ? 8 : m_burst;
             if (m_rem < nb * 4) nb = 1;
             if (int'(fifo_level) >= nb * 4) begin
               r_beats = nb; r_addr = m_addr; r_cmd = m_cmd;
               r_be = m_wo ? 4'h3 : 4'hf; r_hold = m_hold; m_st = 2;
             end
           end
        2: if (req_accept) m_st = 3;
        default: if (resp_valid) begin
             m_rem -= int'(resp_beats) * 4;
             if (!r_hold) m_addr += 32'(resp_beats) * 4;
             if (m_rem == 0) begin m_st = 0; m_done = 1; end else m_st = 1;
           end
      endcase
      if (cfg_we) begin
        m_cmd = cfg_cmd; m_burst = int'(cfg_burst); m_wo = cfg_word_only; m_hold = cfg_addr_hold;
      end
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && monitor_on) begin
      chk("R8 req_valid", {31'd0, req_valid}, {31'd0, m_st == 2});
      chk("R10 pkt_done", {31'd0, pkt_done}, {31'd0, m_done});
      chk("R11 busy", {31'd0, busy}, {31'd0, m_st != 0});
      if (pkt_done) done_seen++;
      if (m_st == 2) begin
        chk("R2 R12 req_cmd", {28'd0, req_cmd}, {28'd0, r_cmd});
        chk("R3 R5 req_beats", {28'd0, req_beats}, 32'(r_beats));
        chk("R6 req_be", {28'd0, req_be}, {28'd0, r_be});
        chk("R7 R9 req_addr", req_addr, r_addr);
      end
    end
  end

  // FIFO level and bus responder
  int rs = 0, held = 0, dly = 0;
  always @(negedge clk) begin
    fifo_level = fifo_rand ? 10'($urandom % 41) : 10'd64;
    req_accept = 1'b0;
    resp_valid = 1'b0;
    if (rs == 0) begin
      if (req_valid && ($urandom % 4) != 0) begin
        req_accept = 1'b1; held = int'(req_beats); rs = 1; dly = $urandom % 3;
      end
    end else if (dly > 0) begin
      dly--;
    end else begin
      resp_valid = 1'b1;
      resp_beats = (disc_en && ($urandom % 3) == 0) ? 4'($urandom % held) : 4'(held);
      rs = 0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic set_cfg(input logic [3:0] c, input logic [2:0] b, input bit wo, input bit h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cmd = c; cfg_burst = b; cfg_word_only = wo; cfg_addr_hold = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 0 plain, 1 stray start while busy, 2 settings write mid-packet
  task automatic send_pkt(input logic [31:0] a, input logic [15:0] len, input int mode);
    @(negedge clk);
    pkt_start = 1'b1; pkt_addr = a; pkt_len = len;
    pkts++;
    @(negedge clk);
    pkt_start = 1'b0;
    if (mode != 0 && len >= 16) begin
      @(negedge clk);
      if (mode == 1) begin
        pkt_start = 1'b1; pkt_addr = 32'hdead_0000; pkt_len = 16'd8;   // R11 ignored
      end else begin
        cfg_we = 1'b1; cfg_cmd = 4'($urandom); cfg_burst = 3'($urandom);  // R12
        cfg_word_only = 1'($urandom); cfg_addr_hold = 1'($urandom);
      end
      @(negedge clk);
      pkt_start = 1'b0; cfg_we = 1'b0;
    end
    while (!pkt_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_valid after reset", {31'd0, req_valid}, 32'd0);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 pkt_done after reset", {31'd0, pkt_done}, 32'd0);
    monitor_on = 1;

    // R1 defaults seen on the first request: command 0111, 8 beats, all lanes
    fork
      send_pkt(32'h1000, 16'd100, 0);
      begin
        while (!req_valid) @(negedge clk);
        chk("R1 default cmd", {28'd0, req_cmd}, 32'd7);
        chk("R1 default beats", {28'd0, req_beats}, 32'd8);
        chk("R1 default be", {28'd0, req_be}, 32'hf);
      end
    join

    // R3 R5 R6 R4: 2-beat bursts, low lanes only, FIFO random
    fifo_rand = 1;
    set_cfg(4'h6, 3'd2, 1, 0);
    send_pkt(32'h2000, 16'd40, 0);

    // R7 R9: fixed address with disconnects
    disc_en = 1;
    set_cfg(4'h7, 3'd3, 0, 1);
    send_pkt(32'h3000, 16'd60, 0);

    // R10 zero length
    send_pkt(32'h4000, 16'd0, 0);

    // R11 stray start while busy
    set_cfg(4'h7, 3'd0, 0, 0);
    send_pkt(32'h5000, 16'd64, 1);

    // Mixed traffic with mid-packet settings writes (R12)
    for (int i = 0; i < 24; i++) begin
      set_cfg(4'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      send_pkt(32'h8000 + 32'(i) * 32'h100, 16'(4 * ($urandom % 30)), i % 3);
    end

    repeat (4) @(negedge clk);
    chk("R10 packet count", 32'(done_seen), 32'(pkts));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule